// File: doc/BRIEF.md
# Receive Byte Queue with Trigger Level and Idle Timeout

This block is the receive side of a 16550-style serial controller, seen from the data path. Bytes from the deserializer enter a 16-entry circular queue. The host drains them through the receive buffer read strobe. A write strobe carries the FIFO control byte. The block decodes that byte into the queue enable, the receive and transmit flushes, and the trigger-level select.

The block drives four signals into the interrupt arbiter:
- the fill count;
- the trigger level in bytes;
- a data-ready flag;
- a character-timeout pending flag.

The timeout is counted in character times. An external one-clock pulse, `tick_char`, marks the end of each character time. When the queue is disabled, a single holding byte replaces it.

The timeout logic is a three-state machine:
- `TMO_IDLE`: no timer running.
- `TMO_RUN`: counting character ticks.
- `TMO_PEND`: timeout signalled.

Its transitions, in priority order:
1. Flush or queue disabled: any state goes to `TMO_IDLE`.
2. Restart (a byte arrives, or a host read leaves data behind): any state goes to `TMO_RUN` with the tick count zeroed.
3. Any other host read: the state goes to `TMO_IDLE`.
4. Expiry: `TMO_RUN` goes to `TMO_PEND` if data remains, otherwise to `TMO_IDLE`.

Top module: `rx_fifo_ctl`

## Requirements
- R1: In queue mode (enable bit 0 set), accepted bytes are read back in arrival order, at most 16 are held, and `rx_count` equals the number held.
- R2: Bits 1 and 2 of the control byte act once and are not stored; only bits 7, 6, 3 and 0 are retained. After writing 0xCB, a write of 0xC9 has no effect.
- R3: Control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes, shown on `trig_lvl`.
- R4: A control write that changes bit 0 flushes the receive queue and pulses `tx_flush`, whatever bits 1 and 2 hold.
- R5: A control write equal to the stored value causes no flush and leaves the queue untouched.
- R6: A receive flush (bit 1, or R4) empties the queue and clears data ready, overrun and timeout pending, and it stops the timer. Bit 2 pulses `tx_flush` in the same cycle as the write.
- R7: In queue mode, timeout pending is set when four `tick_char` pulses follow the last accepted byte, or the last read that left data, and the queue is not empty.
- R8: Any host read of the receive buffer clears timeout pending in the next cycle.
- R9: In queue mode, data ready sets on a push and clears only when a read empties the queue. In holding mode, a push overwrites the single byte and sets data ready, and any read clears it.
- R10: A read of an empty queue returns 0x00 and changes nothing. A push into a full queue is dropped and sets `overrun`.
- R11: After reset, the queue is disabled and empty, the trigger level is 1, and data ready, timeout pending and overrun are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fcr_wr | input | 1 | Control byte write strobe |
| fcr_wdata | input | 8 | Control byte value |
| rx_valid | input | 1 | Deserializer byte strobe |
| rx_byte | input | 8 | Deserialized byte |
| rbr_rd | input | 1 | Host read of the receive buffer |
| rbr_data | output | 8 | Byte presented to the host (head of queue, or holding byte) |
| tick_char | input | 1 | One-clock pulse per character time |
| fifo_en | output | 1 | Queue mode active |
| tx_flush | output | 1 | Same-cycle request to flush the transmit queue |
| rx_count | output | 5 | Bytes held in the receive queue |
| trig_lvl | output | 5 | Trigger level in bytes |
| data_ready | output | 1 | Receive data available |
| tmo_pend | output | 1 | Character timeout pending |
| overrun | output | 1 | Byte lost to a full queue |

## Verification
A wrong head or tail pointer shows on the very next read as a byte out of order, or as a count that disagrees with the bytes pushed. A stuck or skipped timer state shows as `tmo_pend` rising one tick early or late, or not clearing in the cycle after a read. A decoder that stores its one-shot bits, or misses a toggle of the enable bit, shows in the write cycle itself, as a wrong `tx_flush` pulse, and in the next cycle as a count that should have dropped to zero.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

    typedef enum logic [1:0] {
        TMO_IDLE = 2'd0,
        TMO_RUN  = 2'd1,
        TMO_PEND = 2'd2
    } tmo_state_t;

    localparam logic [7:0] FCR_KEEP_MASK = 8'hC9;

    function automatic int trig_bytes(input logic [1:0] code);
        unique case (code)
            2'b00: return 1;
            2'b01: return 4;
            2'b10: return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxf_fcr_dec.sv
module rxf_fcr_dec
    import rxf_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr,
    input  logic [7:0] wdata,
    output logic       fifo_en,
    output logic [1:0] trig_code,
    output logic       rx_flush,
    output logic       tx_flush
);

    logic [7:0] fcr_q;
    logic       changed;
    logic       en_toggle;

    assign changed   = wr && (wdata != fcr_q);
    assign en_toggle = wdata[0] ^ fcr_q[0];
    assign rx_flush  = changed && (wdata[1] || en_toggle);
    assign tx_flush  = changed && (wdata[2] || en_toggle);
    assign fifo_en   = fcr_q[0];
    assign trig_code = fcr_q[7:6];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       fcr_q <= '0;
        else if (changed) fcr_q <= wdata & FCR_KEEP_MASK;
    end

endmodule

// File: rtl/rxf_store.sv
module rxf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             fifo_mode,
    input  logic             push,
    input  logic [DW-1:0]    push_data,
    input  logic             pop,
    output logic [DW-1:0]    rd_data,
    output logic [CNT_W-1:0] count,
    output logic             dr,
    output logic             ovr
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] head, tail;
    logic [DW-1:0]    hold;
    logic             full, empty, wr_en, rd_en;

    assign full  = (count == FULL_CNT);
    assign empty = (count == '0);
    assign wr_en = fifo_mode && push && !full && !flush;
    assign rd_en = fifo_mode && pop && !empty && !flush;

    always_comb begin
        if (fifo_mode) rd_data = empty ? '0 : mem[tail];
        else           rd_data = hold;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[head] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head <= '0; tail <= '0; count <= '0;
            hold <= '0; dr <= 1'b0; ovr <= 1'b0;
        end else if (flush) begin
            head <= '0; tail <= '0; count <= '0;
            hold <= '0; dr <= 1'b0; ovr <= 1'b0;
        end else if (fifo_mode) begin
            if (push && full) ovr <= 1'b1;
            if (wr_en) head <= (head == LAST_PTR) ? '0 : head + 1'b1;
            if (rd_en) tail <= (tail == LAST_PTR) ? '0 : tail + 1'b1;
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
            if (wr_en)                         dr <= 1'b1;
            else if (rd_en && count == 1'b1)   dr <= 1'b0;
        end else begin
            if (push) begin
                hold <= push_data;
                dr   <= 1'b1;
            end else if (pop) begin
                dr   <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
    import rxf_pkg::*;
#(
    parameter int TMO_CHARS = 4,
    localparam int TC_W = (TMO_CHARS > 1) ? $clog2(TMO_CHARS) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush,
    input  logic enable,
    input  logic restart,
    input  logic rd,
    input  logic tick,
    input  logic has_data,
    output logic pend
);

    localparam logic [TC_W-1:0] LAST_TICK = TC_W'(TMO_CHARS - 1);

    tmo_state_t st, nxt;
    logic [TC_W-1:0] ticks;

    always_comb begin
        nxt = st;
        if (flush || !enable) begin
            nxt = TMO_IDLE;
        end else if (restart) begin
            nxt = TMO_RUN;
        end else if (rd) begin
            nxt = TMO_IDLE;
        end else begin
            unique case (st)
                TMO_IDLE: nxt = TMO_IDLE;
                TMO_RUN:  if (tick && ticks == LAST_TICK)
                              nxt = has_data ? TMO_PEND : TMO_IDLE;
                TMO_PEND: nxt = TMO_PEND;
                default:  nxt = TMO_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= TMO_IDLE;
            ticks <= '0;
        end else begin
            st <= nxt;
            if (restart)                 ticks <= '0;
            else if (st == TMO_RUN && tick) ticks <= ticks + 1'b1;
        end
    end

    always_comb begin
        pend = (st == TMO_PEND);
    end

endmodule

// File: rtl/rx_fifo_ctl.sv
module rx_fifo_ctl
    import rxf_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int DW        = 8,
    parameter int TMO_CHARS = 4,
    localparam int CNT_W    = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fcr_wr,
    input  logic [7:0]       fcr_wdata,
    input  logic             rx_valid,
    input  logic [DW-1:0]    rx_byte,
    input  logic             rbr_rd,
    output logic [DW-1:0]    rbr_data,
    input  logic             tick_char,
    output logic             fifo_en,
    output logic             tx_flush,
    output logic [CNT_W-1:0] rx_count,
    output logic [CNT_W-1:0] trig_lvl,
    output logic             data_ready,
    output logic             tmo_pend,
    output logic             overrun
);

    logic [1:0] trig_code;
    logic       rx_flush;
    logic       restart;

    rxf_fcr_dec u_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (fcr_wr),
        .wdata     (fcr_wdata),
        .fifo_en   (fifo_en),
        .trig_code (trig_code),
        .rx_flush  (rx_flush),
        .tx_flush  (tx_flush)
    );

    assign trig_lvl = CNT_W'(trig_bytes(trig_code));

    rxf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (rx_flush),
        .fifo_mode (fifo_en),
        .push      (rx_valid),
        .push_data (rx_byte),
        .pop       (rbr_rd),
        .rd_data   (rbr_data),
        .count     (rx_count),
        .dr        (data_ready),
        .ovr       (overrun)
    );

    assign restart = fifo_en && (rx_valid || (rbr_rd && rx_count > 1));

    rxf_timeout #(.TMO_CHARS(TMO_CHARS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (rx_flush),
        .enable   (fifo_en),
        .restart  (restart),
        .rd       (rbr_rd),
        .tick     (tick_char),
        .has_data (rx_count != '0),
        .pend     (tmo_pend)
    );

endmodule

// File: rtl/rxf_checks.sv
module rxf_checks #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fcr_wr,
    input logic [7:0]       fcr_wdata,
    input logic [7:0]       fcr_q,
    input logic             rx_valid,
    input logic             rbr_rd,
    input logic             fifo_en,
    input logic             tx_flush,
    input logic [CNT_W-1:0] rx_count,
    input logic             data_ready,
    input logic             tmo_pend,
    input logic             overrun
);

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CNT_W'(DEPTH)); // R1

    AST_TOGGLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && (fcr_wdata[0] != fifo_en) |=> rx_count == '0 && !tmo_pend); // R4

    AST_SAME_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_wdata == fcr_q && !rx_valid && !rbr_rd |=> $stable(rx_count)); // R5

    AST_SAME_WRITE_NO_TX: assert property (@(posedge clk) disable iff (!rst_n)
        fcr_wr && fcr_wdata == fcr_q |-> !tx_flush); // R5

    AST_PEND_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_pend |-> rx_count != '0); // R7

    AST_READ_CLEARS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        rbr_rd |=> !tmo_pend); // R8

    AST_DR_TRACKS_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en |-> data_ready == (rx_count != '0)); // R9

    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_en && rx_count == CNT_W'(DEPTH) && rx_valid && !rbr_rd && !fcr_wr
        |=> overrun && rx_count == CNT_W'(DEPTH)); // R10

endmodule

bind rx_fifo_ctl rxf_checks #(.DEPTH(DEPTH)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .fcr_wr     (fcr_wr),
    .fcr_wdata  (fcr_wdata),
    .fcr_q      (u_dec.fcr_q),
    .rx_valid   (rx_valid),
    .rbr_rd     (rbr_rd),
    .fifo_en    (fifo_en),
    .tx_flush   (tx_flush),
    .rx_count   (rx_count),
    .data_ready (data_ready),
    .tmo_pend   (tmo_pend),
    .overrun    (overrun)
);

// File: tb/tb_rx_fifo_ctl.sv
module tb_rx_fifo_ctl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       rbr_rd = 1'b0;
    logic [7:0] rbr_data;
    logic       tick_char = 1'b0;
    logic       fifo_en, tx_flush, data_ready, tmo_pend, overrun;
    logic [4:0] rx_count, trig_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;
    logic [7:0] sb_q[$];

    always #2.5 clk = ~clk;

    rx_fifo_ctl dut (
        .clk(clk), .rst_n(rst_n), .fcr_wr(fcr_wr), .fcr_wdata(fcr_wdata),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rbr_rd(rbr_rd),
        .rbr_data(rbr_data), .tick_char(tick_char), .fifo_en(fifo_en),
        .tx_flush(tx_flush), .rx_count(rx_count), .trig_lvl(trig_lvl),
        .data_ready(data_ready), .tmo_pend(tmo_pend), .overrun(overrun)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wfcr(input logic [7:0] v, input int exp_tx, input string req);
        fcr_wr = 1'b1; fcr_wdata = v;
        #1 check(req, int'(tx_flush), exp_tx);
        @(negedge clk);
        fcr_wr = 1'b0;
    endtask

    // driver: pushes a byte and records it in the scoreboard when it should be kept
    task automatic push(input logic [7:0] b, input bit keep);
        rx_valid = 1'b1; rx_byte = b;
        @(negedge clk);
        rx_valid = 1'b0;
        if (keep) sb_q.push_back(b);
    endtask

    // monitor: pops the scoreboard and compares with the byte the design presents
    task automatic rd(input string req);
        logic [7:0] exp;
        exp = (sb_q.size() != 0) ? sb_q.pop_front() : 8'h00;
        #1 check(req, int'(rbr_data), int'(exp));
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
    endtask

    task automatic tk(input int n);
        for (int i = 0; i < n; i++) begin
            tick_char = 1'b1;
            @(negedge clk);
            tick_char = 1'b0;
        end
    endtask

    task automatic summary;
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        check("R11 count", int'(rx_count), 0);
        check("R11 en", int'(fifo_en), 0);
        check("R11 trig", int'(trig_lvl), 1);
        check("R11 flags", int'({data_ready, tmo_pend, overrun}), 0);

        // R9 holding mode
        push(8'h5A, 0);
        check("R9 hold dr", int'(data_ready), 1);
        push(8'h33, 0);
        #1 check("R9 hold overwrite", int'(rbr_data), 8'h33);
        rbr_rd = 1'b1; @(negedge clk); rbr_rd = 1'b0;
        check("R9 hold read clears", int'(data_ready), 0);

        // R4 enable toggle pulses both flushes
        wfcr(8'h01, 1, "R4 enable tx_flush");
        check("R4 enabled", int'(fifo_en), 1);

        // R3 trigger map
        wfcr(8'hC1, 0, "R3 no tx");
        check("R3 trig 11", int'(trig_lvl), 14);
        wfcr(8'h81, 0, "R3 no tx");
        check("R3 trig 10", int'(trig_lvl), 8);
        wfcr(8'h41, 0, "R3 no tx");
        check("R3 trig 01", int'(trig_lvl), 4);
        wfcr(8'h01, 0, "R3 no tx");
        check("R3 trig 00", int'(trig_lvl), 1);

        // R5 equal write
        push(8'hA1, 1); push(8'hA2, 1);
        wfcr(8'h01, 0, "R5 same no tx");
        check("R5 count kept", int'(rx_count), 2);

        // R1 ordering, R9 data ready, R10 empty read
        push(8'hA3, 1);
        check("R1 count", int'(rx_count), 3);
        rd("R1 order");
        check("R9 dr held", int'(data_ready), 1);
        rd("R1 order");
        check("R9 dr held", int'(data_ready), 1);
        rd("R1 order");
        check("R9 dr cleared", int'(data_ready), 0);
        rd("R10 empty read");
        check("R10 empty count", int'(rx_count), 0);

        // R7 / R8 timeout after push
        push(8'h77, 1);
        tk(3);
        check("R7 early", int'(tmo_pend), 0);
        tk(1);
        check("R7 expire", int'(tmo_pend), 1);
        rd("R1 order");
        check("R8 read clears", int'(tmo_pend), 0);

        // R7 restart after read leaving data
        push(8'h10, 1); push(8'h11, 1);
        tk(4);
        check("R7 expire2", int'(tmo_pend), 1);
        rd("R1 order");
        check("R8 clear2", int'(tmo_pend), 0);
        check("R1 count1", int'(rx_count), 1);
        tk(3);
        check("R7 restart early", int'(tmo_pend), 0);
        tk(1);
        check("R7 restart expire", int'(tmo_pend), 1);
        rd("R1 order");
        check("R8 clear3", int'(tmo_pend), 0);

        // R10 full queue
        for (int i = 0; i < 17; i++) push(8'h40 + 8'(i), i < 16);
        check("R10 full count", int'(rx_count), 16);
        check("R10 overrun", int'(overrun), 1);
        tk(4);
        check("R7 full pend", int'(tmo_pend), 1);

        // R6 receive flush
        wfcr(8'h03, 0, "R6 rx flush no tx");
        sb_q.delete();
        check("R6 count", int'(rx_count), 0);
        check("R6 flags", int'({data_ready, tmo_pend, overrun}), 0);
        tk(6);
        check("R6 timer stopped", int'(tmo_pend), 0);
        wfcr(8'h05, 1, "R6 tx flush bit");

        // R2 one-shot bits are not retained
        push(8'h21, 1); push(8'h22, 1);
        wfcr(8'hCB, 0, "R2 no tx");
        sb_q.delete();
        check("R2 flushed", int'(rx_count), 0);
        check("R2 trig", int'(trig_lvl), 14);
        push(8'h23, 1);
        wfcr(8'hC9, 0, "R2 same no tx");
        check("R2 no-op", int'(rx_count), 1);
        rd("R1 order");

        // R4 disable flushes
        push(8'h24, 1);
        wfcr(8'h00, 1, "R4 disable tx_flush");
        sb_q.delete();
        check("R4 disable count", int'(rx_count), 0);
        check("R4 disabled", int'(fifo_en), 0);
        check("R4 dr", int'(data_ready), 0);

        @(negedge clk);
        summary();
    end

endmodule